// File: doc/BRIEF.md
# Saturating Converter Output Demultiplexer

This block sits behind a conversion core that delivers one signed result per sample clock. Each result is shifted into an 8-bit offset-binary code and clamped to that range. When a result cannot be shown as a code, the block raises an out-of-range flag. The clamped samples then move through a fixed pipeline and are split in pairs onto two half-rate output buses. The first sample of each pair goes to a delayed bus and the second to a primary bus. Both buses change on the same clock edge. A half-rate bus clock marks the cycle that follows each update.

A receiver-side interleaver is built into the same top level. It rebuilds the full-rate stream from the two buses by issuing the delayed-bus word and then the primary-bus word, so samples return in the order they were acquired, one per clock. A power-down level freezes all conversion and transport. While it is high, the buses keep their words and every flag reads zero.

Top module: `sdmx_top`

## Requirements
- R1: A raw input r in the range -128..127 gives the code r+128, with the out-of-range flag 0.
- R2: A raw input below -128 gives code 8'h00, with the out-of-range flag 1.
- R3: A raw input above 127 gives code 8'hFF, with the out-of-range flag 1.
- R4: Active clocks are counted from 0 at the first edge that sees rst_n high. A sample taken at an odd active clock j appears on the primary bus (pri_code, pri_oor) after active edge j+7. It stays there until the next update.
- R5: A sample taken at an even active clock j appears on the delayed bus (dly_code, dly_oor) after active edge j+8. Both buses update only at those edges, which come every second active clock.
- R6: bus_clk is 1 in the cycle after an edge that updated the buses, and 0 after every other active edge. Two active edges never both leave it at 1.
- R7: While pd is 1, a clock edge changes no code, pipeline or phase state. It clears pri_oor, dly_oor and rx_oor. bus_clk and rx_valid hold. Once pd returns to 0, the latencies in R4, R5 and R8 count active clocks only.
- R8: The interleaver presents on rx_code and rx_oor each sample taken at active clock j, after active edge j+9, in acquisition order. rx_valid rises with the first word and then stays 1 until reset.
- R9: An edge with rst_n low clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd | input | 1 | Power-down level, freezes conversion when high |
| raw | input | RAW_W (10) | Two's-complement conversion result |
| pri_code | output | 8 | Primary bus code (second sample of each pair) |
| pri_oor | output | 1 | Primary bus out-of-range flag |
| dly_code | output | 8 | Delayed bus code (first sample of each pair) |
| dly_oor | output | 1 | Delayed bus out-of-range flag |
| bus_clk | output | 1 | Half-rate bus clock, high after each bus update |
| rx_code | output | 8 | Re-interleaved full-rate code |
| rx_oor | output | 1 | Re-interleaved out-of-range flag |
| rx_valid | output | 1 | High once the re-interleaved stream has started |

## Verification
The primary bus is due 7 active clocks after a sample is taken and the delayed bus 8. bus_clk is due one edge after each update, and the rebuilt stream 9 edges after acquisition. Edges with pd high do not count toward any of these delays. The bench keeps a behavioural model that indexes every accepted sample by its active-clock number. It takes each bus word from that history at the index the latency names, and it steps the model once per edge with the inputs that edge will see. All outputs are compared at the falling edge that follows. Power-down bursts of different lengths, a mid-run reset and samples at and beyond both clamp limits test the points where the count pauses or restarts.

// File: rtl/sdmx_pkg.sv
`timescale 1ns/1ps
// Shared types for the saturating output demultiplexer.
// Assumes the output code width is fixed at 8 bits for every instance.
package sdmx_pkg;
    localparam int CODE_W = 8;

    // One sample in flight through the transport pipeline.
    typedef struct packed {
        logic [CODE_W-1:0] code;  // clamped offset-binary code
        logic              oor;   // out-of-range flag
        logic              ph;    // 0 = first of a pair, 1 = second
        logic              vld;   // slot holds an accepted sample
    } smp_t;
endpackage

// File: rtl/sdmx_sat.sv
`timescale 1ns/1ps
// Converts a two's-complement result to offset binary and clamps it.
// Pure combinational logic. Assumes RAW_W is larger than the code width.
module sdmx_sat #(
    parameter int RAW_W = 10
) (
    input  logic [RAW_W-1:0]           raw,
    output logic [sdmx_pkg::CODE_W-1:0] code,
    output logic                        oor
);
    localparam int CW       = sdmx_pkg::CODE_W;
    localparam int EXT_W    = RAW_W + 1;
    localparam int OFFSET   = 2 ** (CW - 1);
    localparam int CODE_MAX = (2 ** CW) - 1;

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] sum;

    // Shift by half scale, then clamp to the code range.
    always_comb begin
        ext = {raw[RAW_W-1], raw};
        sum = ext + $signed(EXT_W'(OFFSET));
        if (sum < 0) begin
            code = '0;
            oor  = 1'b1;
        end else if (sum > $signed(EXT_W'(CODE_MAX))) begin
            code = '1;
            oor  = 1'b1;
        end else begin
            code = sum[CW-1:0];
            oor  = 1'b0;
        end
    end
endmodule

// File: rtl/sdmx_pipe.sv
`timescale 1ns/1ps
// Full-rate transport delay line with a tap at every stage.
// Tap i holds the sample taken i+1 active edges ago. Assumes DEPTH >= 2.
module sdmx_pipe #(
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  sdmx_pkg::smp_t                din,
    output sdmx_pkg::smp_t [DEPTH-1:0]    taps
);
    // Shift one stage per active clock, hold while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (en) begin
            taps <= {taps[DEPTH-2:0], din};
        end
    end
endmodule

// File: rtl/sdmx_demux.sv
`timescale 1ns/1ps
// Loads the two half-rate buses from the delay-line taps.
// The primary bus takes second-of-pair samples from its tap and the delayed
// bus takes first-of-pair samples from the tap one stage further on, so both
// buses load on the same edge. Flags clear while disabled.
module sdmx_demux (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  sdmx_pkg::smp_t                tap_p,
    input  sdmx_pkg::smp_t                tap_d,
    output logic [sdmx_pkg::CODE_W-1:0]   pri_code,
    output logic                          pri_oor,
    output logic [sdmx_pkg::CODE_W-1:0]   dly_code,
    output logic                          dly_oor,
    output logic                          bus_clk
);
    logic load_p;
    logic load_d;

    // Decide which bus accepts its tap this edge.
    always_comb begin
        load_p = tap_p.vld & tap_p.ph;
        load_d = tap_d.vld & ~tap_d.ph;
    end

    // Bus registers and the half-rate marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_code <= '0;
            pri_oor  <= 1'b0;
            dly_code <= '0;
            dly_oor  <= 1'b0;
            bus_clk  <= 1'b0;
        end else if (!en) begin
            pri_oor  <= 1'b0;
            dly_oor  <= 1'b0;
        end else begin
            if (load_p) begin
                pri_code <= tap_p.code;
                pri_oor  <= tap_p.oor;
            end
            if (load_d) begin
                dly_code <= tap_d.code;
                dly_oor  <= tap_d.oor;
            end
            bus_clk <= load_d;
        end
    end
endmodule

// File: rtl/sdmx_ilv.sv
`timescale 1ns/1ps
// Receiver-side interleaver. It rebuilds the full-rate stream by issuing the
// delayed-bus word in the cycle after a bus update and the primary-bus word
// in the cycle after that. Assumes both buses update on the same edge.
module sdmx_ilv (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          bus_clk,
    input  logic [sdmx_pkg::CODE_W-1:0]   pri_code,
    input  logic                          pri_oor,
    input  logic [sdmx_pkg::CODE_W-1:0]   dly_code,
    input  logic                          dly_oor,
    output logic [sdmx_pkg::CODE_W-1:0]   rx_code,
    output logic                          rx_oor,
    output logic                          rx_valid
);
    logic seen_q;

    // Pick the delayed word after an update and the primary word otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_code  <= '0;
            rx_oor   <= 1'b0;
            rx_valid <= 1'b0;
            seen_q   <= 1'b0;
        end else if (!en) begin
            rx_oor   <= 1'b0;
        end else if (bus_clk) begin
            rx_code  <= dly_code;
            rx_oor   <= dly_oor;
            rx_valid <= 1'b1;
            seen_q   <= 1'b1;
        end else if (seen_q) begin
            rx_code  <= pri_code;
            rx_oor   <= pri_oor;
        end
    end
endmodule

// File: rtl/sdmx_top.sv
`timescale 1ns/1ps
// Saturating converter output demultiplexer with its receiver interleaver.
// Each active clock takes one raw result, clamps it to offset binary and
// tags it with its pair phase. The sample then moves through a full-rate
// delay line whose taps feed the two half-rate buses. pd high freezes every
// stage. Assumes LAT_PRI >= 1.
module sdmx_top #(
    parameter int RAW_W   = 10,
    parameter int LAT_PRI = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pd,
    input  logic [RAW_W-1:0]              raw,
    output logic [sdmx_pkg::CODE_W-1:0]   pri_code,
    output logic                          pri_oor,
    output logic [sdmx_pkg::CODE_W-1:0]   dly_code,
    output logic                          dly_oor,
    output logic                          bus_clk,
    output logic [sdmx_pkg::CODE_W-1:0]   rx_code,
    output logic                          rx_oor,
    output logic                          rx_valid
);
    import sdmx_pkg::*;

    localparam int LAT_DLY = LAT_PRI + 1;

    logic                       en;
    logic                       phase_q;
    logic [CODE_W-1:0]          sat_code;
    logic                       sat_oor;
    smp_t                       s_in;
    smp_t [LAT_DLY-1:0]         taps;

    // Conversion runs only while power-down is low.
    always_comb en = ~pd;

    // Pair phase: alternates on every active clock, starting at 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (en) begin
            phase_q <= ~phase_q;
        end
    end

    sdmx_sat #(.RAW_W(RAW_W)) u_sat (
        .raw  (raw),
        .code (sat_code),
        .oor  (sat_oor)
    );

    // Assemble the sample that enters the delay line.
    always_comb begin
        s_in.code = sat_code;
        s_in.oor  = sat_oor;
        s_in.ph   = phase_q;
        s_in.vld  = 1'b1;
    end

    sdmx_pipe #(.DEPTH(LAT_DLY)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .din   (s_in),
        .taps  (taps)
    );

    sdmx_demux u_demux (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tap_p    (taps[LAT_PRI-1]),
        .tap_d    (taps[LAT_DLY-1]),
        .pri_code (pri_code),
        .pri_oor  (pri_oor),
        .dly_code (dly_code),
        .dly_oor  (dly_oor),
        .bus_clk  (bus_clk)
    );

    sdmx_ilv u_ilv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bus_clk  (bus_clk),
        .pri_code (pri_code),
        .pri_oor  (pri_oor),
        .dly_code (dly_code),
        .dly_oor  (dly_oor),
        .rx_code  (rx_code),
        .rx_oor   (rx_oor),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/sdmx_chk.sv
`timescale 1ns/1ps
// Temporal checks on the demultiplexer ports, bound into every sdmx_top.
module sdmx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd,
    input logic [7:0] pri_code,
    input logic       pri_oor,
    input logic [7:0] dly_code,
    input logic       dly_oor,
    input logic       bus_clk,
    input logic       rx_oor,
    input logic       rx_valid
);
    AST_PRI_OOR_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
        pri_oor |-> (pri_code == 8'h00 || pri_code == 8'hFF)); // R2 R3
    AST_DLY_OOR_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
        dly_oor |-> (dly_code == 8'h00 || dly_code == 8'hFF)); // R2 R3
    AST_BUS_CHANGE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$stable(pri_code) || !$stable(dly_code))) |-> bus_clk); // R5
    AST_BUS_CLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clk && !pd) |=> !bus_clk); // R6
    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> ($stable(pri_code) && $stable(dly_code) && $stable(bus_clk))); // R7
    AST_PD_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (!pri_oor && !dly_oor && !rx_oor)); // R7
    AST_RX_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_valid); // R8
endmodule

bind sdmx_top sdmx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd       (pd),
    .pri_code (pri_code),
    .pri_oor  (pri_oor),
    .dly_code (dly_code),
    .dly_oor  (dly_oor),
    .bus_clk  (bus_clk),
    .rx_oor   (rx_oor),
    .rx_valid (rx_valid)
);

// File: tb/tb_sdmx_top.sv
`timescale 1ns/1ps
// Bench for sdmx_top: a behavioural model indexed by active-clock number,
// stepped once per edge and compared at every falling edge.
module tb_sdmx_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pd;
    logic [9:0] raw;
    logic [7:0] pri_code, dly_code, rx_code;
    logic       pri_oor, dly_oor, bus_clk, rx_oor, rx_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state.
    int hc [0:4095];
    int ho [0:4095];
    int n_act;
    int mpc, mpo, mdc, mdo, mbclk, mrc, mro, mrv, mseen;
    bit m_in_rst, m_in_pd;

    sdmx_top dut (
        .clk(clk), .rst_n(rst_n), .pd(pd), .raw(raw),
        .pri_code(pri_code), .pri_oor(pri_oor),
        .dly_code(dly_code), .dly_oor(dly_oor), .bus_clk(bus_clk),
        .rx_code(rx_code), .rx_oor(rx_oor), .rx_valid(rx_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string flag_tag(input int code, input int oor);
        if (oor == 1 && code == 0)   return "R2";
        if (oor == 1 && code == 255) return "R3";
        return "R1";
    endfunction

    // Compare all outputs against the model state left by the last edge.
    task automatic compare();
        string tp, td, tc, tr;
        tp = "R4"; td = "R5"; tc = "R6"; tr = "R8";
        if (m_in_rst) begin
            tp = "R9"; td = "R9"; tc = "R9"; tr = "R9";
        end else if (m_in_pd) begin
            tp = "R7"; td = "R7"; tc = "R7"; tr = "R7";
        end
        chk(tp, "pri_code", int'(pri_code), mpc);
        chk(m_in_rst ? "R9" : (m_in_pd ? "R7" : flag_tag(mpc, mpo)), "pri_oor", int'(pri_oor), mpo);
        chk(td, "dly_code", int'(dly_code), mdc);
        chk(m_in_rst ? "R9" : (m_in_pd ? "R7" : flag_tag(mdc, mdo)), "dly_oor", int'(dly_oor), mdo);
        chk(tc, "bus_clk", int'(bus_clk), mbclk);
        chk(tr, "rx_code", int'(rx_code), mrc);
        chk(tr, "rx_oor", int'(rx_oor), mro);
        chk(tr, "rx_valid", int'(rx_valid), mrv);
    endtask

    // Advance the model by one edge using the inputs that edge will see.
    task automatic model_edge(input bit r, input bit p, input int v);
        int e, s;
        bit lp, ld;
        m_in_rst = !r;
        m_in_pd  = r && p;
        if (!r) begin
            n_act = 0; mpc = 0; mpo = 0; mdc = 0; mdo = 0; mbclk = 0;
            mrc = 0; mro = 0; mrv = 0; mseen = 0;
        end else if (p) begin
            mpo = 0; mdo = 0; mro = 0;
        end else begin
            e = n_act;
            s = v + 128;
            if (s < 0)        begin hc[e] = 0;   ho[e] = 1; end
            else if (s > 255) begin hc[e] = 255; ho[e] = 1; end
            else              begin hc[e] = s;   ho[e] = 0; end
            if (mbclk == 1) begin
                mrc = mdc; mro = mdo; mseen = 1; mrv = 1;
            end else if (mseen == 1) begin
                mrc = mpc; mro = mpo;
            end
            lp = (e >= 7) && (((e - 7) % 2) == 1);
            ld = (e >= 8) && (((e - 8) % 2) == 0);
            if (lp) begin mpc = hc[e-7]; mpo = ho[e-7]; end
            if (ld) begin mdc = hc[e-8]; mdo = ho[e-8]; end
            mbclk = ld ? 1 : 0;
            n_act++;
        end
    endtask

    task automatic step(input bit r, input bit p, input int v);
        @(negedge clk);
        compare();
        rst_n = r;
        pd    = p;
        raw   = v[9:0];
        model_edge(r, p, v);
    endtask

    function automatic int rnd_raw();
        return int'($urandom_range(1023, 0)) - 512;
    endfunction

    initial begin
        int edges[6];
        rst_n = 1'b0; pd = 1'b0; raw = '0;
        model_edge(1'b0, 1'b0, 0);
        // R9: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0);
        // R1: in-range ramp across the full code span
        for (int v = -128; v <= 127; v += 9) step(1'b1, 1'b0, v);
        // R2 R3: values at and beyond both clamp limits
        edges = '{-512, -129, -128, 127, 128, 511};
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 6; i++) step(1'b1, 1'b0, edges[(i + k) % 6]);
        // R4 R5 R6 R8: random full-scale stream
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, rnd_raw());
        // R7: power-down bursts of varied length between active runs
        for (int b = 1; b <= 6; b++) begin
            for (int i = 0; i < b; i++) step(1'b1, 1'b1, rnd_raw());
            for (int i = 0; i < b + 2; i++) step(1'b1, 1'b0, (i % 2 == 0) ? 511 : rnd_raw());
        end
        // R9: reset mid-stream, then restart
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, rnd_raw());
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0, rnd_raw());
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, -512);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, rnd_raw());
        step(1'b1, 1'b0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule